// File: doc/BRIEF.md
# Burst Framing Monitor

This block watches the write-address, write-data, read-address and read-data channels of one AXI port without driving any of them. Each address handshake fixes the number of beats in a burst as the length field plus one. That count goes into a small in-order queue. The monitor then counts the beats that complete on the matching data channel. It reports a framing error when the LAST flag appears on a beat that is not the final one, or when the final beat arrives without LAST. Bursts cannot stop early, so every burst must deliver exactly its announced number of beats.

A parameter selects the length cap. The older mode allows at most 16 beats and the newer mode allows at most 256. A per-channel watchdog reports a stall when VALID has waited too long for READY. Every error class has a single-cycle pulse and a sticky flag that holds until reset.

The monitor is meant for bus fabrics and for verification harnesses that need hardware checks on burst framing. It assumes that an address never arrives after the first data beat of its burst. An address in the same cycle as that beat is accepted.

Top module: `axi_burst_monitor`

## Requirements
- R1: A beat counts only at a clock edge where VALID and READY of its data channel are both high. VALID without READY changes no count and raises no framing error.
- R2: If WLAST is high on a completed write beat that is not the final beat of the head burst, the write framing error is raised.
- R3: If the final beat of the head write burst completes with WLAST low, the write framing error is raised.
- R4: On the read data channel, an early RLAST or a missing RLAST on the final beat raises the read framing error. Correctly framed bursts raise nothing.
- R5: A burst's beat count is its 8-bit length field plus one. With AXI4_MODE=0, an address handshake announcing more than 16 beats (field value 16 or more) raises the length error. With AXI4_MODE=1 the cap is 256 beats, so no 8-bit field value trips it.
- R6: Each direction queues up to QDEPTH (default 4) pending burst lengths and serves them in order. An address handshake that finds the queue full, with no pop in that cycle, raises that direction's framing error.
- R7: A data beat that completes with no pending burst and no address handshake in the same cycle raises that direction's framing error. A one-beat burst whose address and LAST beat complete at the same edge is legal.
- R8: If VALID is high and READY is low at STALL_LIMIT (default 5) consecutive edges on a channel, that channel's stall bit pulses once for that stall episode. Bit order of the stall vectors: 0 write address, 1 write data, 2 read address, 3 read data.
- R9: Each pulse output is high for the one cycle after the edge where its error occurred. The matching sticky flag rises at the same time and stays high until reset.
- R10: Reset (rst_ni low) clears queues, counters, pulses and sticky flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| aw_valid_i | input | 1 | Write address VALID |
| aw_ready_i | input | 1 | Write address READY |
| aw_len_i | input | LEN_W | Write burst length field (beats minus one) |
| w_valid_i | input | 1 | Write data VALID |
| w_ready_i | input | 1 | Write data READY |
| w_last_i | input | 1 | Write LAST flag |
| ar_valid_i | input | 1 | Read address VALID |
| ar_ready_i | input | 1 | Read address READY |
| ar_len_i | input | LEN_W | Read burst length field (beats minus one) |
| r_valid_i | input | 1 | Read data VALID |
| r_ready_i | input | 1 | Read data READY |
| r_last_i | input | 1 | Read LAST flag |
| wr_frame_err_o | output | 1 | Sticky write framing error |
| rd_frame_err_o | output | 1 | Sticky read framing error |
| len_err_o | output | 1 | Sticky length-cap error |
| stall_err_o | output | 4 | Sticky stall flags, one per channel |
| wr_frame_pulse_o | output | 1 | Write framing error pulse |
| rd_frame_pulse_o | output | 1 | Read framing error pulse |
| len_pulse_o | output | 1 | Length-cap error pulse |
| stall_pulse_o | output | 4 | Stall pulses, one per channel |

## Verification
The hardest state to reach from the ports is a full length queue meeting one more address handshake. In ordinary traffic the data beats drain the queue before it fills. The stimulus gets there by issuing several address handshakes back to back with the data channel held idle, so the overflow shows up on exactly the fifth address.

The same-cycle bypass is also hard to reach, because random traffic rarely lines up an address and its only beat at one edge. It gets a directed case. Random legal bursts with bounded READY stalls then confirm that no flag rises falsely, in both length-cap modes at once.

// File: rtl/axi_burst_mon_pkg.sv
package axi_burst_mon_pkg;
  localparam int NUM_CH = 4;
  typedef enum logic [1:0] {
    CH_AW = 2'd0,
    CH_W  = 2'd1,
    CH_AR = 2'd2,
    CH_R  = 2'd3
  } chan_e;
  typedef struct packed {
    logic valid;
    logic ready;
  } hs_t;
endpackage

// File: rtl/burst_len_fifo.sv
module burst_len_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic do_pop, do_push;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign head_o  = mem_q[rd_q];
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_pop)  rd_q <= next_ptr(rd_q);
      if (do_push) wr_q <= next_ptr(wr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end
endmodule

// File: rtl/beat_tracker.sv
module beat_tracker #(
  parameter int LEN_W     = 8,
  parameter int QDEPTH    = 4,
  parameter bit AXI4_MODE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             addr_fire_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             beat_fire_i,
  input  logic             last_i,
  output logic             frame_err_o,
  output logic             len_err_o
);
  localparam int CNT_W     = LEN_W + 1;
  localparam int MAX_BEATS = AXI4_MODE ? 256 : 16;

  logic [CNT_W-1:0] beats_in, head, expect_beats, cnt_q, cnt_nxt;
  logic empty, full, have_burst, is_final, bypass_done;
  logic push, pop, overflow, orphan, bad_last;

  assign beats_in     = CNT_W'(len_i) + 1'b1;
  assign len_err_o    = addr_fire_i && (beats_in > CNT_W'(MAX_BEATS));

  // Same-cycle address serves an empty queue directly.
  assign have_burst   = !empty || addr_fire_i;
  assign expect_beats = empty ? beats_in : head;
  assign cnt_nxt      = cnt_q + 1'b1;
  assign is_final     = (cnt_nxt == expect_beats);

  assign bypass_done  = empty && addr_fire_i && beat_fire_i && is_final;
  assign pop          = beat_fire_i && !empty && is_final;
  assign push         = addr_fire_i && !bypass_done;

  assign overflow     = push && full && !pop;
  assign orphan       = beat_fire_i && !have_burst;
  assign bad_last     = beat_fire_i && have_burst && (last_i != is_final);
  assign frame_err_o  = overflow || orphan || bad_last;

  burst_len_fifo #(.DEPTH(QDEPTH), .WIDTH(CNT_W)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .data_i (beats_in),
    .head_o (head),
    .empty_o(empty),
    .full_o (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (beat_fire_i && have_burst) begin
      cnt_q <= is_final ? '0 : cnt_nxt;
    end
  end
endmodule

// File: rtl/ready_watch.sv
module ready_watch #(
  parameter int STALL_LIMIT = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic ready_i,
  output logic stall_o
);
  localparam int CNT_W = $clog2(STALL_LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic waiting;

  assign waiting = valid_i && !ready_i;
  assign stall_o = waiting && (cnt_q == CNT_W'(STALL_LIMIT - 1));

  // Saturates at the limit so one episode fires once.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (!waiting)                          cnt_q <= '0;
    else if (cnt_q != CNT_W'(STALL_LIMIT))      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/axi_burst_monitor.sv
module axi_burst_monitor
  import axi_burst_mon_pkg::*;
#(
  parameter bit AXI4_MODE   = 1'b0,
  parameter int LEN_W       = 8,
  parameter int QDEPTH      = 4,
  parameter int STALL_LIMIT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             aw_valid_i,
  input  logic             aw_ready_i,
  input  logic [LEN_W-1:0] aw_len_i,
  input  logic             w_valid_i,
  input  logic             w_ready_i,
  input  logic             w_last_i,
  input  logic             ar_valid_i,
  input  logic             ar_ready_i,
  input  logic [LEN_W-1:0] ar_len_i,
  input  logic             r_valid_i,
  input  logic             r_ready_i,
  input  logic             r_last_i,
  output logic             wr_frame_err_o,
  output logic             rd_frame_err_o,
  output logic             len_err_o,
  output logic [3:0]       stall_err_o,
  output logic             wr_frame_pulse_o,
  output logic             rd_frame_pulse_o,
  output logic             len_pulse_o,
  output logic [3:0]       stall_pulse_o
);
  hs_t [NUM_CH-1:0] hs;
  logic [NUM_CH-1:0] stall_evt;
  logic wr_frame_evt, rd_frame_evt, wr_len_evt, rd_len_evt;

  assign hs[CH_AW] = '{valid: aw_valid_i, ready: aw_ready_i};
  assign hs[CH_W]  = '{valid: w_valid_i,  ready: w_ready_i};
  assign hs[CH_AR] = '{valid: ar_valid_i, ready: ar_ready_i};
  assign hs[CH_R]  = '{valid: r_valid_i,  ready: r_ready_i};

  beat_tracker #(.LEN_W(LEN_W), .QDEPTH(QDEPTH), .AXI4_MODE(AXI4_MODE)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_fire_i(aw_valid_i && aw_ready_i),
    .len_i      (aw_len_i),
    .beat_fire_i(w_valid_i && w_ready_i),
    .last_i     (w_last_i),
    .frame_err_o(wr_frame_evt),
    .len_err_o  (wr_len_evt)
  );

  beat_tracker #(.LEN_W(LEN_W), .QDEPTH(QDEPTH), .AXI4_MODE(AXI4_MODE)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_fire_i(ar_valid_i && ar_ready_i),
    .len_i      (ar_len_i),
    .beat_fire_i(r_valid_i && r_ready_i),
    .last_i     (r_last_i),
    .frame_err_o(rd_frame_evt),
    .len_err_o  (rd_len_evt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_watch
    ready_watch #(.STALL_LIMIT(STALL_LIMIT)) u_watch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(hs[c].valid),
      .ready_i(hs[c].ready),
      .stall_o(stall_evt[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_frame_pulse_o <= 1'b0;
      rd_frame_pulse_o <= 1'b0;
      len_pulse_o      <= 1'b0;
      stall_pulse_o    <= '0;
      wr_frame_err_o   <= 1'b0;
      rd_frame_err_o   <= 1'b0;
      len_err_o        <= 1'b0;
      stall_err_o      <= '0;
    end else begin
      wr_frame_pulse_o <= wr_frame_evt;
      rd_frame_pulse_o <= rd_frame_evt;
      len_pulse_o      <= wr_len_evt || rd_len_evt;
      stall_pulse_o    <= stall_evt;
      wr_frame_err_o   <= wr_frame_err_o || wr_frame_evt;
      rd_frame_err_o   <= rd_frame_err_o || rd_frame_evt;
      len_err_o        <= len_err_o || wr_len_evt || rd_len_evt;
      stall_err_o      <= stall_err_o | stall_evt;
    end
  end
endmodule

// File: rtl/axi_burst_mon_chk.sv
module axi_burst_mon_chk #(
  parameter bit AXI4_MODE   = 1'b0,
  parameter int LEN_W       = 8,
  parameter int STALL_LIMIT = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             aw_valid_i,
  input logic             aw_ready_i,
  input logic [LEN_W-1:0] aw_len_i,
  input logic             w_valid_i,
  input logic             w_ready_i,
  input logic             ar_valid_i,
  input logic             ar_ready_i,
  input logic [LEN_W-1:0] ar_len_i,
  input logic             r_valid_i,
  input logic             r_ready_i,
  input logic             wr_frame_err_o,
  input logic             rd_frame_err_o,
  input logic             len_pulse_o,
  input logic             wr_frame_pulse_o,
  input logic             rd_frame_pulse_o,
  input logic [3:0]       stall_pulse_o
);
  localparam int CAP = AXI4_MODE ? 256 : 16;
  localparam int CW  = $clog2(STALL_LIMIT + 1);

  logic aw_hs, ar_hs, aw_big, ar_big;
  logic [3:0] vv, rr;
  assign aw_hs  = aw_valid_i && aw_ready_i;
  assign ar_hs  = ar_valid_i && ar_ready_i;
  assign aw_big = aw_hs && (int'(aw_len_i) >= CAP);
  assign ar_big = ar_hs && (int'(ar_len_i) >= CAP);
  assign vv = {r_valid_i, ar_valid_i, w_valid_i, aw_valid_i};
  assign rr = {r_ready_i, ar_ready_i, w_ready_i, aw_ready_i};

  p_idle_wr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(w_valid_i && w_ready_i) && !aw_hs) |=> !wr_frame_pulse_o);
  p_idle_rd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(r_valid_i && r_ready_i) && !ar_hs) |=> !rd_frame_pulse_o);
  p_len_cap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aw_big || ar_big) |=> len_pulse_o);
  p_len_ok_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!aw_big && !ar_big) |=> !len_pulse_o);
  p_sticky_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_frame_pulse_o |-> wr_frame_err_o) and (rd_frame_pulse_o |-> rd_frame_err_o));
  p_sticky_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_frame_err_o |=> wr_frame_err_o);

  for (genvar c = 0; c < 4; c++) begin : g_stall
    logic [CW-1:0] wait_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       wait_q <= '0;
      else if (!(vv[c] && !rr[c]))       wait_q <= '0;
      else if (wait_q != CW'(STALL_LIMIT)) wait_q <= wait_q + 1'b1;
    end
    p_stall_fire_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vv[c] && !rr[c] && wait_q == CW'(STALL_LIMIT - 1)) |=> stall_pulse_o[c]);
    p_stall_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!vv[c] || rr[c]) |=> !stall_pulse_o[c]);
  end
endmodule

bind axi_burst_monitor axi_burst_mon_chk #(
  .AXI4_MODE(AXI4_MODE), .LEN_W(LEN_W), .STALL_LIMIT(STALL_LIMIT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .aw_valid_i(aw_valid_i), .aw_ready_i(aw_ready_i), .aw_len_i(aw_len_i),
  .w_valid_i(w_valid_i), .w_ready_i(w_ready_i),
  .ar_valid_i(ar_valid_i), .ar_ready_i(ar_ready_i), .ar_len_i(ar_len_i),
  .r_valid_i(r_valid_i), .r_ready_i(r_ready_i),
  .wr_frame_err_o(wr_frame_err_o), .rd_frame_err_o(rd_frame_err_o),
  .len_pulse_o(len_pulse_o), .wr_frame_pulse_o(wr_frame_pulse_o),
  .rd_frame_pulse_o(rd_frame_pulse_o), .stall_pulse_o(stall_pulse_o)
);

// File: tb/axi_burst_monitor_test.sv
module axi_burst_monitor_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic aw_valid_i = 0, aw_ready_i = 0, w_valid_i = 0, w_ready_i = 0, w_last_i = 0;
  logic ar_valid_i = 0, ar_ready_i = 0, r_valid_i = 0, r_ready_i = 0, r_last_i = 0;
  logic [7:0] aw_len_i = '0, ar_len_i = '0;
  logic wr_err, rd_err, len_err, wr_p, rd_p, len_p;
  logic [3:0] st_err, st_p;
  logic wr_err4, rd_err4, len_err4, wr_p4, rd_p4, len_p4;
  logic [3:0] st_err4, st_p4;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  axi_burst_monitor #(.AXI4_MODE(1'b0)) uut (
    .clk_i, .rst_ni, .aw_valid_i, .aw_ready_i, .aw_len_i, .w_valid_i, .w_ready_i,
    .w_last_i, .ar_valid_i, .ar_ready_i, .ar_len_i, .r_valid_i, .r_ready_i, .r_last_i,
    .wr_frame_err_o(wr_err), .rd_frame_err_o(rd_err), .len_err_o(len_err),
    .stall_err_o(st_err), .wr_frame_pulse_o(wr_p), .rd_frame_pulse_o(rd_p),
    .len_pulse_o(len_p), .stall_pulse_o(st_p));

  axi_burst_monitor #(.AXI4_MODE(1'b1)) uut4 (
    .clk_i, .rst_ni, .aw_valid_i, .aw_ready_i, .aw_len_i, .w_valid_i, .w_ready_i,
    .w_last_i, .ar_valid_i, .ar_ready_i, .ar_len_i, .r_valid_i, .r_ready_i, .r_last_i,
    .wr_frame_err_o(wr_err4), .rd_frame_err_o(rd_err4), .len_err_o(len_err4),
    .stall_err_o(st_err4), .wr_frame_pulse_o(wr_p4), .rd_frame_pulse_o(rd_p4),
    .len_pulse_o(len_p4), .stall_pulse_o(st_p4));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] flags();
    return {wr_err, rd_err, len_err, st_err, wr_p, rd_p, len_p, st_p};
  endfunction

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic wr_addr(input logic [7:0] len);
    aw_valid_i = 1; aw_ready_i = 1; aw_len_i = len;
    tick();
    aw_valid_i = 0; aw_ready_i = 0;
  endtask

  task automatic rd_addr(input logic [7:0] len);
    ar_valid_i = 1; ar_ready_i = 1; ar_len_i = len;
    tick();
    ar_valid_i = 0; ar_ready_i = 0;
  endtask

  task automatic wr_beat(input logic last);
    w_valid_i = 1; w_ready_i = 1; w_last_i = last;
    tick();
    w_valid_i = 0; w_ready_i = 0; w_last_i = 0;
  endtask

  task automatic rd_beat(input logic last);
    r_valid_i = 1; r_ready_i = 1; r_last_i = last;
    tick();
    r_valid_i = 0; r_ready_i = 0; r_last_i = 0;
  endtask

  // Random legal write or read burst with short READY stalls.
  task automatic rand_burst(input bit is_rd);
    int n = $urandom_range(15, 0);
    int st;
    if (is_rd) begin ar_len_i = 8'(n); ar_valid_i = 1; end
    else       begin aw_len_i = 8'(n); aw_valid_i = 1; end
    st = $urandom_range(3, 0);
    for (int s = 0; s < st; s++) tick();
    if (is_rd) ar_ready_i = 1; else aw_ready_i = 1;
    tick();
    ar_valid_i = 0; ar_ready_i = 0; aw_valid_i = 0; aw_ready_i = 0;
    for (int b = 0; b <= n; b++) begin
      if (is_rd) begin r_valid_i = 1; r_last_i = (b == n); end
      else       begin w_valid_i = 1; w_last_i = (b == n); end
      st = $urandom_range(4, 0);
      for (int s = 0; s < st; s++) tick();
      if (is_rd) r_ready_i = 1; else w_ready_i = 1;
      tick();
      r_valid_i = 0; r_ready_i = 0; r_last_i = 0;
      w_valid_i = 0; w_ready_i = 0; w_last_i = 0;
      if ($urandom_range(1, 0) == 1) tick();
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    tick();
    chk("R10 reset state", flags(), 0);
    chk("R10 reset state axi4", {wr_err4, rd_err4, len_err4, st_err4}, 0);
    rst_ni = 1'b1;
    tick();

    // R2/R3 correct four-beat write
    wr_addr(8'd3);
    wr_beat(0); wr_beat(0); wr_beat(0); wr_beat(1);
    chk("R2 clean write burst", flags(), 0);

    // R1 valid without ready does not count
    wr_addr(8'd1);
    w_valid_i = 1; w_ready_i = 0; w_last_i = 0;
    tick(); tick();
    w_valid_i = 0;
    chk("R1 stalled beat not counted", wr_p, 0);
    wr_beat(0);
    wr_beat(1);
    chk("R1 two beats after stall", wr_err, 0);

    // R2 early WLAST on beat 2 of 3
    wr_addr(8'd2);
    wr_beat(0);
    wr_beat(1);
    chk("R2 early wlast pulse", wr_p, 1);
    chk("R9 sticky with pulse", wr_err, 1);
    tick();
    chk("R9 pulse is one cycle", wr_p, 0);
    chk("R9 sticky holds", wr_err, 1);
    do_reset();
    chk("R10 reset clears sticky", flags(), 0);

    // R3 missing WLAST on final beat
    wr_addr(8'd1);
    wr_beat(0);
    chk("R3 no error mid burst", wr_p, 0);
    wr_beat(0);
    chk("R3 missing wlast", wr_p, 1);
    do_reset();

    // R4 read framing
    rd_addr(8'd2);
    rd_beat(0); rd_beat(0); rd_beat(1);
    chk("R4 clean read", {rd_err, wr_err}, 0);
    rd_addr(8'd2);
    rd_beat(1);
    chk("R4 early rlast", rd_p, 1);
    chk("R4 write side untouched", wr_err, 0);
    do_reset();
    rd_addr(8'd0);
    rd_beat(0);
    chk("R4 missing rlast", rd_p, 1);
    do_reset();

    // R5 length caps, both modes side by side
    wr_addr(8'd15);
    chk("R5 16 beats ok axi3", len_p, 0);
    wr_addr(8'd16);
    chk("R5 17 beats axi3", len_p, 1);
    chk("R5 17 beats axi4", len_p4, 0);
    do_reset();
    rd_addr(8'd255);
    chk("R5 256 beats axi3", len_err, 1);
    chk("R5 256 beats axi4", len_err4, 0);
    do_reset();

    // R6 in-order queue of three bursts
    wr_addr(8'd1); wr_addr(8'd0); wr_addr(8'd2);
    wr_beat(0); wr_beat(1);
    wr_beat(1);
    wr_beat(0); wr_beat(0); wr_beat(1);
    chk("R6 queued bursts in order", wr_err, 0);
    // R6 overflow on fifth pending address
    wr_addr(8'd0); wr_addr(8'd0); wr_addr(8'd0); wr_addr(8'd0);
    chk("R6 four pending ok", wr_err, 0);
    wr_addr(8'd0);
    chk("R6 overflow", wr_p, 1);
    do_reset();

    // R7 orphan beat and same-cycle bypass
    wr_beat(1);
    chk("R7 orphan beat", wr_p, 1);
    do_reset();
    aw_valid_i = 1; aw_ready_i = 1; aw_len_i = 8'd0;
    wr_beat(1);
    aw_valid_i = 0; aw_ready_i = 0;
    chk("R7 same-cycle single beat", wr_err, 0);
    wr_beat(1);
    chk("R7 bypass consumed burst", wr_p, 1);
    do_reset();

    // R8 stall watchdog on write address
    aw_valid_i = 1; aw_ready_i = 0; aw_len_i = 8'd0;
    for (int i = 0; i < 4; i++) tick();
    aw_ready_i = 1;
    tick();
    aw_valid_i = 0; aw_ready_i = 0;
    chk("R8 four waits no stall", st_err, 0);
    wr_beat(1);
    do_reset();
    aw_valid_i = 1; aw_ready_i = 0;
    for (int i = 0; i < 4; i++) tick();
    chk("R8 not yet", st_p, 0);
    tick();
    chk("R8 stall pulse bit0", st_p, 4'b0001);
    tick();
    chk("R8 single pulse per episode", {st_p, st_err}, {4'b0000, 4'b0001});
    aw_valid_i = 0;
    do_reset();
    r_valid_i = 1; r_ready_i = 0;
    for (int i = 0; i < 5; i++) tick();
    r_valid_i = 0;
    chk("R8 read data stall bit3", st_err, 4'b1000);
    do_reset();

    // Random legal traffic: no flag may rise in either mode
    for (int k = 0; k < 40; k++) begin
      rand_burst(k[0]);
      chk("R1 random legal traffic", flags(), 0);
      chk("R5 random legal traffic axi4", {wr_err4, rd_err4, len_err4, st_err4}, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule